// File: doc/BRIEF.md
# DMA Interrupt Status and Enable Register Group

This block holds the interrupt-reporting registers of a script-driven DMA/SCSI controller. A byte-wide read/write bus reaches five registers: a DMA mode byte, a DMA interrupt enable mask, a DMA control byte, a read-only DMA status byte and a read-only interrupt status byte. The script engine sends single-cycle event pulses when it executes an interrupt instruction or completes a single step. Each event is always recorded in the status registers. The interrupt request output is raised only for causes whose enable bit is set, so a status bit can be latched while no interrupt is signalled.

The block also drives a halt flag, which an interrupt instruction sets and a start strobe clears. It drives a single-step mode flag, which it decodes from the control byte. Software clears the recorded causes by reading the DMA status byte. Writing the enable mask re-evaluates the request against causes that are already latched, so a cause that was masked earlier can be raised later by unmasking it.

Top module: `dma_irq_regs`

## Requirements
- R1: Reset state: the DMA status byte (offset 0x0C) reads 0x80, with bit 7 meaning the FIFO is empty. The interrupt status byte (offset 0x14), the mode byte, the enable mask and the control byte all read 0x00. The irq, halt and step_mode outputs are low.
- R2: The mode byte (offset 0x38), the enable mask (offset 0x39) and the control byte (offset 0x3B) store all eight bits written and read them back unchanged.
- R3: An interrupt-instruction pulse sets DMA status bit 2 and interrupt status bit 0, and it raises halt. All three are visible on the clock after the pulse.
- R4: A single-step completion pulse sets DMA status bit 3 and interrupt status bit 0. Both are visible on the clock after the pulse.
- R5: irq is high exactly when DMA status bit 2 and enable bit 2 are both set, or when DMA status bit 3 and enable bit 3 are both set. Enable bits other than 2 and 3 have no effect on irq.
- R6: A write to the enable mask changes irq on the next clock, based on the status bits already latched.
- R7: A read of the DMA status byte returns its current value. On that clock it clears bits 2 and 3 and keeps bit 7. After that, irq and interrupt status bit 0 are low. An event pulsed in the same cycle as the read stays set.
- R8: A start strobe clears halt on the next clock. If an interrupt-instruction pulse arrives in the same cycle as the strobe, halt stays set.
- R9: step_mode is high exactly when control bits 4 and 2 are both set (mask 0x14).
- R10: Reads of unmapped offsets return 0x00. Writes to the two status bytes or to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| evt_int_instr | input | 1 | Interrupt instruction executed (pulse) |
| evt_step_done | input | 1 | Single step completed (pulse) |
| start_strobe | input | 1 | Restart pulse that clears halt |
| irq | output | 1 | Interrupt request |
| halt | output | 1 | Script execution halted |
| step_mode | output | 1 | Single-step mode active |

## Verification
Several rules are checked by assertions on every cycle. Each event pulse must be followed by its status bit, the pending bit and, for an interrupt instruction, halt. A status read with no event in the same cycle must leave both cause bits clear. A start strobe without a same-cycle event must drop halt. A rising irq must trace back to an event or an enable write, and a rising step_mode must trace back to a control write.

Some behaviour can only be shown by the bench's scenarios:
- the exact byte values returned on reads;
- the masking of a latched cause and its later raising by an enable write;
- the survival of an event that arrives during a status read;
- the inertness of writes to read-only and unmapped offsets.

// File: rtl/dma_irq_pkg.sv
// Package: shared constants of the DMA interrupt register group.
// Assumes byte-wide registers. Cause index 0 is the interrupt instruction,
// cause index 1 is single-step completion.
package dma_irq_pkg;
    localparam int BYTE_W   = 8;
    localparam int NCAUSE   = 2;
    localparam int CAUSE_INT  = 0;
    localparam int CAUSE_STEP = 1;
    // Bit positions of each cause in the DMA status and enable bytes.
    localparam int CAUSE_POS [NCAUSE] = '{2, 3};
    localparam int FIFO_EMPTY_POS = 7;
    localparam int PEND_POS       = 0;
    localparam int STEP_BIT_A     = 4;
    localparam int STEP_BIT_B     = 2;
    localparam logic [BYTE_W-1:0] STAT_RESET = 8'h80;
endpackage

// File: rtl/dma_irq_ctlregs.sv
// Module: dma_irq_ctlregs
// Holds the three software-owned bytes: mode, enable mask and control.
// It also decodes single-step mode from the control byte.
// Assumes one bus access per strobe cycle. Writes take effect on the next clock.
module dma_irq_ctlregs
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] OFF_MODE = 'h38,
    parameter logic [ADDR_W-1:0] OFF_EN   = 'h39,
    parameter logic [ADDR_W-1:0] OFF_CTL  = 'h3B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] mode_q,
    output logic [BYTE_W-1:0] en_q,
    output logic [BYTE_W-1:0] ctl_q,
    output logic              step_mode
);
    logic wr_mode, wr_en, wr_ctl;

    // Address decode of the three writable bytes
    always_comb begin
        wr_mode = wr_stb && (addr == OFF_MODE);
        wr_en   = wr_stb && (addr == OFF_EN);
        wr_ctl  = wr_stb && (addr == OFF_CTL);
    end

    // Register update on decoded write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            en_q   <= '0;
            ctl_q  <= '0;
        end else begin
            if (wr_mode) mode_q <= wdata;
            if (wr_en)   en_q   <= wdata;
            if (wr_ctl)  ctl_q  <= wdata;
        end
    end

    // Single-step decode: both control bits must be set
    always_comb step_mode = ctl_q[STEP_BIT_A] && ctl_q[STEP_BIT_B];

    // step_mode may only rise after a control write
    assert_step_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(step_mode) |-> $past(wr_ctl));
endmodule

// File: rtl/dma_irq_status.sv
// Module: dma_irq_status
// Records event pulses in the DMA status byte and the pending bit.
// A status read clears the cause bits. It also keeps the halt flag.
// Assumes event pulses are one cycle wide. An event beats a same-cycle clear.
module dma_irq_status
    import dma_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCAUSE-1:0] evt,
    input  logic              rd_stat,
    input  logic              start_strobe,
    output logic [BYTE_W-1:0] stat_q,
    output logic              pend_q,
    output logic              halt
);
    logic [BYTE_W-1:0] stat_nxt;

    // Next status: clear causes on read, then set the new events
    always_comb begin
        stat_nxt = stat_q;
        for (int c = 0; c < NCAUSE; c++) begin
            if (rd_stat) stat_nxt[CAUSE_POS[c]] = 1'b0;
        end
        for (int c = 0; c < NCAUSE; c++) begin
            if (evt[c]) stat_nxt[CAUSE_POS[c]] = 1'b1;
        end
    end

    // Status byte register
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= STAT_RESET;
        else        stat_q <= stat_nxt;
    end

    // Pending bit: set by any event, dropped by a clearing read
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (|evt)    pend_q <= 1'b1;
        else if (rd_stat) pend_q <= 1'b0;
    end

    // Halt flag: set by interrupt instruction, cleared by start
    always_ff @(posedge clk) begin
        if (!rst_n)              halt <= 1'b0;
        else if (evt[CAUSE_INT]) halt <= 1'b1;
        else if (start_strobe)   halt <= 1'b0;
    end

    assert_int_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt[CAUSE_INT] |=> (stat_q[CAUSE_POS[CAUSE_INT]] && pend_q && halt));
    assert_step_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt[CAUSE_STEP] |=> (stat_q[CAUSE_POS[CAUSE_STEP]] && pend_q));
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !(|evt)) |=> (!stat_q[CAUSE_POS[0]] && !stat_q[CAUSE_POS[1]]
                                  && !pend_q && stat_q[FIFO_EMPTY_POS]));
    assert_halt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_strobe && !evt[CAUSE_INT]) |=> !halt);
endmodule

// File: rtl/dma_irq_readmux.sv
// Module: dma_irq_readmux
// Read data selection for all mapped bytes.
// Unmapped offsets return zero. Purely combinational.
module dma_irq_readmux
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] OFF_MODE  = 'h38,
    parameter logic [ADDR_W-1:0] OFF_EN    = 'h39,
    parameter logic [ADDR_W-1:0] OFF_CTL   = 'h3B,
    parameter logic [ADDR_W-1:0] OFF_STAT  = 'h0C,
    parameter logic [ADDR_W-1:0] OFF_ISTAT = 'h14
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] mode_q,
    input  logic [BYTE_W-1:0] en_q,
    input  logic [BYTE_W-1:0] ctl_q,
    input  logic [BYTE_W-1:0] stat_q,
    input  logic              pend_q,
    output logic [BYTE_W-1:0] rdata
);
    // Offset to byte selection
    always_comb begin
        rdata = '0;
        if      (addr == OFF_MODE)  rdata = mode_q;
        else if (addr == OFF_EN)    rdata = en_q;
        else if (addr == OFF_CTL)   rdata = ctl_q;
        else if (addr == OFF_STAT)  rdata = stat_q;
        else if (addr == OFF_ISTAT) rdata[PEND_POS] = pend_q;
    end
endmodule

// File: rtl/dma_irq_regs.sv
// Module: dma_irq_regs (top)
// Interrupt status and enable register group of a script-driven DMA engine.
// Events are always recorded. irq is gated cause by cause by the enable mask.
// Assumes single-cycle bus strobes and a synchronous active-low reset.
module dma_irq_regs
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] OFF_MODE  = 'h38,
    parameter logic [ADDR_W-1:0] OFF_EN    = 'h39,
    parameter logic [ADDR_W-1:0] OFF_CTL   = 'h3B,
    parameter logic [ADDR_W-1:0] OFF_STAT  = 'h0C,
    parameter logic [ADDR_W-1:0] OFF_ISTAT = 'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              evt_int_instr,
    input  logic              evt_step_done,
    input  logic              start_strobe,
    output logic              irq,
    output logic              halt,
    output logic              step_mode
);
    logic              wr_stb, rd_stat, en_wr;
    logic [NCAUSE-1:0] evt, gated;
    logic [BYTE_W-1:0] mode_q, en_q, ctl_q, stat_q;
    logic              pend_q;

    // Bus strobe qualification and event bundling
    always_comb begin
        wr_stb  = bus_sel && bus_wr;
        rd_stat = bus_sel && !bus_wr && (bus_addr == OFF_STAT);
        en_wr   = wr_stb && (bus_addr == OFF_EN);
        evt[CAUSE_INT]  = evt_int_instr;
        evt[CAUSE_STEP] = evt_step_done;
    end

    dma_irq_ctlregs #(.ADDR_W(ADDR_W), .OFF_MODE(OFF_MODE), .OFF_EN(OFF_EN),
                      .OFF_CTL(OFF_CTL)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(bus_addr),
        .wdata(bus_wdata), .mode_q(mode_q), .en_q(en_q), .ctl_q(ctl_q),
        .step_mode(step_mode));

    dma_irq_status u_stat (
        .clk(clk), .rst_n(rst_n), .evt(evt), .rd_stat(rd_stat),
        .start_strobe(start_strobe), .stat_q(stat_q), .pend_q(pend_q),
        .halt(halt));

    dma_irq_readmux #(.ADDR_W(ADDR_W), .OFF_MODE(OFF_MODE), .OFF_EN(OFF_EN),
                      .OFF_CTL(OFF_CTL), .OFF_STAT(OFF_STAT),
                      .OFF_ISTAT(OFF_ISTAT)) u_rd (
        .addr(bus_addr), .mode_q(mode_q), .en_q(en_q), .ctl_q(ctl_q),
        .stat_q(stat_q), .pend_q(pend_q), .rdata(bus_rdata));

    // Per-cause gating of latched status by the enable mask
    for (genvar c = 0; c < NCAUSE; c++) begin : g_gate
        always_comb gated[c] = stat_q[CAUSE_POS[c]] && en_q[CAUSE_POS[c]];
    end

    // Request output: any enabled latched cause
    always_comb irq = |gated;

    // A rising irq needs an event or an enable write on the previous clock
    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((|evt) || en_wr));
    // irq never stands without the pending bit
    assert_irq_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend_q);
endmodule

// File: tb/tb_dma_irq_regs.sv
module tb_dma_irq_regs;
    localparam logic [7:0] A_MODE = 8'h38, A_EN = 8'h39, A_CTL = 8'h3B;
    localparam logic [7:0] A_STAT = 8'h0C, A_ISTAT = 8'h14;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 0, bus_wr = 0, evt_int_instr = 0, evt_step_done = 0, start_strobe = 0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic irq, halt, step_mode;
    int n_chk = 0, n_bad = 0;
    logic [7:0] d;

    always #10 clk = ~clk;

    dma_irq_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_int_instr(evt_int_instr), .evt_step_done(evt_step_done),
        .start_strobe(start_strobe), .irq(irq), .halt(halt), .step_mode(step_mode));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
        #5 v = bus_rdata;
        @(negedge clk); bus_sel = 0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [7:0] e, input string req);
        logic [7:0] v;
        rd(a, v);
        check(v == e, req, v, e);
    endtask

    task automatic pulse(input bit i, input bit s, input bit st);
        @(negedge clk); evt_int_instr = i; evt_step_done = s; start_strobe = st;
        @(negedge clk); evt_int_instr = 0; evt_step_done = 0; start_strobe = 0;
    endtask

    task automatic t_reset;
        check(irq == 0 && halt == 0 && step_mode == 0, "R1 outputs", {irq, halt, step_mode}, 0);
        expect_rd(A_STAT, 8'h80, "R1 status");
        expect_rd(A_ISTAT, 8'h00, "R1 istat");
        expect_rd(A_MODE, 8'h00, "R1 mode");
        expect_rd(A_EN, 8'h00, "R1 enable");
        expect_rd(A_CTL, 8'h00, "R1 control");
    endtask

    task automatic t_regs;
        wr(A_MODE, 8'hA5); wr(A_EN, 8'h5A); wr(A_CTL, 8'h3C);
        expect_rd(A_MODE, 8'hA5, "R2 mode");
        expect_rd(A_EN, 8'h5A, "R2 enable");
        expect_rd(A_CTL, 8'h3C, "R2 control");
        wr(A_MODE, 8'h00); wr(A_EN, 8'h00); wr(A_CTL, 8'h00);
    endtask

    task automatic t_int_masked;
        wr(A_EN, 8'hF3);
        pulse(1, 0, 0);
        check(irq == 0, "R5 masked int", irq, 0);
        check(halt == 1, "R3 halt", halt, 1);
        expect_rd(A_ISTAT, 8'h01, "R3 istat");
        expect_rd(A_STAT, 8'h84, "R3 status");
        expect_rd(A_STAT, 8'h80, "R7 cleared");
        expect_rd(A_ISTAT, 8'h00, "R7 istat drop");
    endtask

    task automatic t_int_enabled;
        wr(A_EN, 8'h04);
        pulse(1, 0, 0);
        check(irq == 1, "R5 enabled int", irq, 1);
        rd(A_STAT, d);
        check(irq == 0, "R7 irq drop", irq, 0);
    endtask

    task automatic t_step;
        pulse(0, 1, 0);
        check(irq == 0, "R5 step masked", irq, 0);
        expect_rd(A_ISTAT, 8'h01, "R4 istat");
        wr(A_EN, 8'h08);
        check(irq == 1, "R6 unmask", irq, 1);
        wr(A_EN, 8'h00);
        check(irq == 0, "R6 remask", irq, 0);
        wr(A_EN, 8'h08);
        expect_rd(A_STAT, 8'h88, "R4 status");
        check(irq == 0, "R7 step cleared", irq, 0);
        wr(A_EN, 8'h00);
    endtask

    task automatic t_race;
        pulse(0, 1, 0);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = A_STAT; evt_int_instr = 1;
        #5 d = bus_rdata;
        @(negedge clk); bus_sel = 0; evt_int_instr = 0;
        check(d == 8'h88, "R7 read value", d, 8'h88);
        expect_rd(A_STAT, 8'h84, "R7 event survives read");
        expect_rd(A_STAT, 8'h80, "R7 second read");
    endtask

    task automatic t_halt;
        pulse(0, 0, 1);
        check(halt == 0, "R8 start clears", halt, 0);
        pulse(1, 0, 1);
        check(halt == 1, "R8 event wins", halt, 1);
        pulse(0, 0, 1);
        check(halt == 0, "R8 clear again", halt, 0);
        rd(A_STAT, d);
    endtask

    task automatic t_step_mode;
        wr(A_CTL, 8'h10); check(step_mode == 0, "R9 bit4 only", step_mode, 0);
        wr(A_CTL, 8'h04); check(step_mode == 0, "R9 bit2 only", step_mode, 0);
        wr(A_CTL, 8'h14); check(step_mode == 1, "R9 both", step_mode, 1);
        wr(A_CTL, 8'hFF); check(step_mode == 1, "R9 all", step_mode, 1);
        wr(A_CTL, 8'h00); check(step_mode == 0, "R9 off", step_mode, 0);
    endtask

    task automatic t_unmapped;
        wr(A_MODE, 8'h11); wr(A_EN, 8'h22); wr(A_CTL, 8'h33);
        expect_rd(8'h00, 8'h00, "R10 read 0x00");
        expect_rd(8'h3A, 8'h00, "R10 read 0x3A");
        expect_rd(8'hFF, 8'h00, "R10 read 0xFF");
        wr(A_STAT, 8'hFF);  expect_rd(A_STAT, 8'h80, "R10 status ro");
        wr(A_ISTAT, 8'hFF); expect_rd(A_ISTAT, 8'h00, "R10 istat ro");
        wr(8'h3A, 8'hEE);
        expect_rd(A_MODE, 8'h11, "R10 mode kept");
        expect_rd(A_EN, 8'h22, "R10 enable kept");
        expect_rd(A_CTL, 8'h33, "R10 control kept");
        check(irq == 0, "R10 irq", irq, 0);
    endtask

    initial begin : watchdog
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0x1 expected=0x0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_regs();
        t_int_masked();
        t_int_enabled();
        t_step();
        t_race();
        t_halt();
        t_step_mode();
        t_unmapped();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule